// File: doc/BRIEF.md
# Write-Through Data Cache with Bypass Control

This block sits between a processor's data port and main memory and keeps recently read 16-bit words in a small direct-mapped store. All addresses are 22-bit physical byte addresses. Reads that hit return in one cycle without touching memory. Reads that miss fetch the word from memory and fill the line. Every write is passed on to memory. A write that hits also updates the line, and a write that misses leaves the store untouched.

Three conditions send an access straight to memory without allocating a line: the address lies in the I/O page, the request carries the per-page no-cache flag, or software has turned the cache off. When a no-cache access finds its word resident, the line is dropped. A later cacheable read then fetches fresh data instead of returning a copy that another bus master may have overwritten. A single-bit control register turns the cache on and off. Turning it back on empties the whole store in the same cycle, so nothing written around the cache while it was off can be returned.

Top module: `wt_dcache`

## Requirements
- R1: After reset the cache is on and every line is invalid. `hit_o`, `cpu_ack_o` and `mem_req_o` are low.
- R2: A cacheable read that misses issues one memory read, returns the memory word and fills the line. It clears `hit_o`.
- R3: A cacheable read that hits is acknowledged one cycle after the request is sampled, with no memory access. It returns the stored word and sets `hit_o`.
- R4: Every write goes to memory. A cacheable write hit updates the stored word, and a write miss allocates nothing, so the next read of that word misses. Writes leave `hit_o` unchanged.
- R5: Addresses 0x3FE000 to 0x3FFFFF (bits 21:13 all ones) always go to memory, are never allocated and leave `hit_o` unchanged.
- R6: An access with `cpu_nocache_i` high goes to memory, allocates nothing and leaves `hit_o` unchanged. If its word is resident, that line is invalidated.
- R7: A control write with `ctl_wdata_i` = 0 turns the cache off. While off, every access goes to memory, no line is allocated or updated, and `hit_o` is unchanged.
- R8: A control write with `ctl_wdata_i` = 1 while the cache is off turns it on and invalidates every line. The same write while it is already on keeps the contents.
- R9: The line index is address bits 8:1 and the tag is bits 21:9. Bit 0 is ignored for lookup, so an odd byte address hits the word of its even neighbour. Two addresses with the same index but different tags evict each other.
- R10: `mem_req_o` stays high with stable `mem_addr_o`, `mem_we_o` and `mem_wdata_o` until `mem_ack_i`. These carry the processor's address, direction and write data. `cpu_ack_o` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Access request, held until `cpu_ack_o` |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 22 | Physical byte address |
| cpu_wdata_i | input | 16 | Write data |
| cpu_nocache_i | input | 1 | Page no-cache flag for this access |
| cpu_ack_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | 16 | Read data, valid with `cpu_ack_o` |
| hit_o | output | 1 | 1 if the latest cacheable read hit |
| mem_req_o | output | 1 | Memory request, held until `mem_ack_i` |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 22 | Memory byte address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_ack_i | input | 1 | Memory completion, one cycle |
| mem_rdata_i | input | 16 | Memory read data, valid with `mem_ack_i` |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 1 | New cache-on value |

## Verification
The design samples a request at a clock edge. On a hit, `cpu_ack_o`, `cpu_rdata_o` and `hit_o` change at the next edge. On any other access, `mem_req_o` rises at the next edge, and the acknowledge and data follow one edge after `mem_ack_i` is sampled. Control writes take effect for requests sampled from the edge after the strobe. The bench drives inputs and reads outputs only on falling edges. It counts the falling edges from request to acknowledge, so a hit must show a count of exactly one. It reads the data and `hit_o` on the falling edge where the acknowledge is seen, and checks on the following falling edge that the acknowledge has dropped.

// File: rtl/wt_dcache_pkg.sv
`timescale 1ns/1ps
package wt_dcache_pkg;
    localparam int unsigned DEF_ADDR_W = 22;
    localparam int unsigned DEF_DATA_W = 16;
    localparam int unsigned DEF_IDX_W  = 8;
    localparam int unsigned DEF_IOPG_W = 13;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MEM  = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/wt_dcache_tags.sv
`timescale 1ns/1ps
module wt_dcache_tags #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned TAG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             wr_en,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             clr_all
);
    localparam int unsigned LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_d;
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Per-line valid next state: a full clear beats a fill, a fill beats a drop.
    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_comb begin
            if (clr_all)
                valid_d[g] = 1'b0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                valid_d[g] = 1'b1;
            else if (inv_en && (wr_idx == IDX_W'(g)))
                valid_d[g] = 1'b0;
            else
                valid_d[g] = valid_q[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_idx] <= wr_tag;
    end

    assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
endmodule

// File: rtl/wt_dcache_data.sv
`timescale 1ns/1ps
module wt_dcache_data #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned LINES = 1 << IDX_W;

    logic [DATA_W-1:0] word_q [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) word_q[wr_idx] <= wr_data;
    end

    assign rd_data = word_q[rd_idx];
endmodule

// File: rtl/wt_dcache_ctrl.sv
`timescale 1ns/1ps
module wt_dcache_ctrl
    import wt_dcache_pkg::*;
#(
    parameter int unsigned ADDR_W = 22,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned IOPG_W = 13,
    parameter int unsigned OFF_W  = 1,
    parameter int unsigned TAG_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    input  logic              cpu_nocache_i,
    output logic              cpu_ack_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              hit_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              ctl_we_i,
    input  logic              ctl_wdata_i,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [TAG_W-1:0]  lk_tag,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] line_rdata,
    output logic              tag_wr,
    output logic              tag_inv,
    output logic              tag_clr,
    output logic              dat_wr,
    output logic [IDX_W-1:0]  line_idx,
    output logic [TAG_W-1:0]  line_tag,
    output logic [DATA_W-1:0] line_wdata
);
    typedef struct packed {
        ctl_state_e        st;
        logic              on;
        logic              ack;
        logic              hit;
        logic [DATA_W-1:0] rdata;
        logic              mreq;
        logic              mwe;
        logic [ADDR_W-1:0] maddr;
        logic [DATA_W-1:0] mwd;
        logic              fill;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;
    logic      reenable;
    logic      hit_eff;
    logic      io_page;
    logic      uncached;

    always_comb begin
        r_d        = r_q;
        r_d.ack    = 1'b0;
        tag_wr     = 1'b0;
        tag_inv    = 1'b0;
        dat_wr     = 1'b0;
        line_idx   = r_q.maddr[OFF_W +: IDX_W];
        line_tag   = r_q.maddr[ADDR_W-1 -: TAG_W];
        line_wdata = mem_rdata_i;
        lk_idx     = cpu_addr_i[OFF_W +: IDX_W];
        lk_tag     = cpu_addr_i[ADDR_W-1 -: TAG_W];

        reenable = ctl_we_i && ctl_wdata_i && !r_q.on;
        tag_clr  = reenable;
        if (ctl_we_i) r_d.on = ctl_wdata_i;

        hit_eff  = lk_hit && !reenable;
        io_page  = &cpu_addr_i[ADDR_W-1:IOPG_W];
        uncached = io_page || cpu_nocache_i || !r_q.on;

        case (r_q.st)
            ST_IDLE: begin
                if (cpu_req_i && !r_q.ack) begin
                    if (!uncached && !cpu_we_i && hit_eff) begin
                        r_d.ack   = 1'b1;
                        r_d.rdata = line_rdata;
                        r_d.hit   = 1'b1;
                    end else begin
                        r_d.st    = ST_MEM;
                        r_d.mreq  = 1'b1;
                        r_d.maddr = cpu_addr_i;
                        r_d.mwe   = cpu_we_i;
                        r_d.mwd   = cpu_wdata_i;
                        r_d.fill  = !uncached && !cpu_we_i;
                        if (cpu_nocache_i && hit_eff) begin
                            tag_inv  = 1'b1;
                            line_idx = lk_idx;
                        end
                        if (!uncached && cpu_we_i && hit_eff) begin
                            dat_wr     = 1'b1;
                            line_idx   = lk_idx;
                            line_wdata = cpu_wdata_i;
                        end
                    end
                end
            end
            ST_MEM: begin
                if (mem_ack_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.mreq = 1'b0;
                    r_d.ack  = 1'b1;
                    if (!r_q.mwe) r_d.rdata = mem_rdata_i;
                    if (r_q.fill) begin
                        r_d.hit = 1'b0;
                        if (!reenable) begin
                            tag_wr = 1'b1;
                            dat_wr = 1'b1;
                        end
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.on    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_ack_o   = r_q.ack;
    assign cpu_rdata_o = r_q.rdata;
    assign hit_o       = r_q.hit;
    assign mem_req_o   = r_q.mreq;
    assign mem_we_o    = r_q.mwe;
    assign mem_addr_o  = r_q.maddr;
    assign mem_wdata_o = r_q.mwd;
endmodule

// File: rtl/wt_dcache.sv
`timescale 1ns/1ps
module wt_dcache
    import wt_dcache_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned IDX_W  = DEF_IDX_W,
    parameter int unsigned IOPG_W = DEF_IOPG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    input  logic              cpu_nocache_i,
    output logic              cpu_ack_o,
    output logic [DATA_W-1:0] cpu_rdata_o,
    output logic              hit_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              ctl_we_i,
    input  logic              ctl_wdata_i
);
    localparam int unsigned OFF_W = $clog2(DATA_W / 8);
    localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_hit;
    logic [DATA_W-1:0] line_rdata;
    logic              tag_wr, tag_inv, tag_clr, dat_wr;
    logic [IDX_W-1:0]  line_idx;
    logic [TAG_W-1:0]  line_tag;
    logic [DATA_W-1:0] line_wdata;

    wt_dcache_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .IOPG_W(IOPG_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
        .cpu_wdata_i(cpu_wdata_i), .cpu_nocache_i(cpu_nocache_i),
        .cpu_ack_o(cpu_ack_o), .cpu_rdata_o(cpu_rdata_o), .hit_o(hit_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit), .line_rdata(line_rdata),
        .tag_wr(tag_wr), .tag_inv(tag_inv), .tag_clr(tag_clr), .dat_wr(dat_wr),
        .line_idx(line_idx), .line_tag(line_tag), .line_wdata(line_wdata)
    );

    wt_dcache_tags #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
        .wr_en(tag_wr), .inv_en(tag_inv), .wr_idx(line_idx), .wr_tag(line_tag),
        .clr_all(tag_clr)
    );

    wt_dcache_data #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
        .clk(clk), .wr_en(dat_wr), .wr_idx(line_idx), .wr_data(line_wdata),
        .rd_idx(lk_idx), .rd_data(line_rdata)
    );
endmodule

// File: rtl/wt_dcache_chk.sv
`timescale 1ns/1ps
module wt_dcache_chk #(
    parameter int unsigned ADDR_W = 22,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned IOPG_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req_i,
    input logic              cpu_we_i,
    input logic [ADDR_W-1:0] cpu_addr_i,
    input logic              cpu_nocache_i,
    input logic              cpu_ack_o,
    input logic              hit_o,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_wdata_o,
    input logic              mem_ack_i
);
    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack_o |=> !cpu_ack_o);

    assert_fast_ack_is_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack_o && !$past(mem_ack_i)) |-> hit_o);

    assert_write_through_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack_o && $past(cpu_req_i) && $past(cpu_we_i)) |-> $past(mem_ack_i));

    assert_io_to_memory_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack_o && $past(cpu_req_i) && $past(&cpu_addr_i[ADDR_W-1:IOPG_W])) |-> $past(mem_ack_i));

    assert_nocache_to_memory_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack_o && $past(cpu_req_i) && $past(cpu_nocache_i)) |-> $past(mem_ack_i));

    assert_mem_only_on_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o) |-> $past(cpu_req_i));
endmodule

bind wt_dcache wt_dcache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IOPG_W(IOPG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i),
    .cpu_addr_i(cpu_addr_i), .cpu_nocache_i(cpu_nocache_i), .cpu_ack_o(cpu_ack_o),
    .hit_o(hit_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i)
);

// File: tb/wt_dcache_bench.sv
`timescale 1ns/1ps
module wt_dcache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_i = 1'b0, cpu_we_i = 1'b0, cpu_nocache_i = 1'b0;
    logic [21:0] cpu_addr_i = '0;
    logic [15:0] cpu_wdata_i = '0;
    logic        cpu_ack_o, hit_o, mem_req_o, mem_we_o;
    logic [15:0] cpu_rdata_o, mem_wdata_o;
    logic [21:0] mem_addr_o;
    logic        mem_ack_i = 1'b0;
    logic [15:0] mem_rdata_i = '0;
    logic        ctl_we_i = 1'b0, ctl_wdata_i = 1'b0;

    int n_chk = 0, n_fail = 0, mem_cnt = 0, wcnt = 0;
    bit finished = 0;
    logic [21:0] last_a;
    logic        last_we;
    logic [15:0] last_wd;
    logic [15:0] mem_aa [int];

    always #2.5 clk = ~clk;

    wt_dcache u_wt_dcache (
        .clk(clk), .rst_n(rst_n), .cpu_req_i(cpu_req_i), .cpu_we_i(cpu_we_i),
        .cpu_addr_i(cpu_addr_i), .cpu_wdata_i(cpu_wdata_i), .cpu_nocache_i(cpu_nocache_i),
        .cpu_ack_o(cpu_ack_o), .cpu_rdata_o(cpu_rdata_o), .hit_o(hit_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i)
    );

    function automatic logic [15:0] model_rd(input logic [21:0] a);
        int k = int'(a[21:1]);
        if (mem_aa.exists(k)) return mem_aa[k];
        return a[16:1] ^ 16'hC3A5;
    endfunction

    // Memory model: acknowledges on the second falling edge of a request.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack_i) mem_ack_i = 1'b0;
            else if (mem_req_o) begin
                wcnt++;
                if (wcnt == 2) begin
                    wcnt = 0;
                    mem_cnt++;
                    last_a = mem_addr_o; last_we = mem_we_o; last_wd = mem_wdata_o;
                    if (mem_we_o) mem_aa[int'(mem_addr_o[21:1])] = mem_wdata_o;
                    else          mem_rdata_i = model_rd(mem_addr_o);
                    mem_ack_i = 1'b1;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic nc, input logic [21:0] a,
                          input logic [15:0] wd, output logic [15:0] rd,
                          output int nmem, output int lat, output logic hit);
        int m0 = mem_cnt;
        @(negedge clk);
        cpu_req_i = 1'b1; cpu_we_i = we; cpu_nocache_i = nc;
        cpu_addr_i = a; cpu_wdata_i = wd;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!cpu_ack_o && lat < 1000);
        rd = cpu_rdata_o; hit = hit_o; nmem = mem_cnt - m0;
        cpu_req_i = 1'b0;
        if (nmem == 1) begin
            chk("R10 mem address", 32'(last_a), 32'(a));
            chk("R10 mem direction", 32'(last_we), 32'(we));
            if (we) chk("R10 mem write data", 32'(last_wd), 32'(wd));
        end
        @(negedge clk);
        chk("R10 ack is one cycle", 32'(cpu_ack_o), 32'd0);
    endtask

    task automatic ctl_write(input logic v);
        @(negedge clk);
        ctl_we_i = 1'b1; ctl_wdata_i = v;
        @(negedge clk);
        ctl_we_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    typedef struct packed {
        logic        we;
        logic        nc;
        logic [21:0] addr;
        logic [15:0] wd;
        logic        exp_mem;
        logic        exp_hit;
    } vec_t;

    localparam logic [21:0] A  = 22'h001234;   // index 0x1A, tag 0x009
    localparam logic [21:0] B  = 22'h001434;   // index 0x1A, tag 0x00A
    localparam logic [21:0] C  = 22'h000400;
    localparam logic [21:0] IO = 22'h3FE010;
    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, A,          16'h0,    1'b1, 1'b0},  // R2 miss fills
        '{1'b0, 1'b0, A,          16'h0,    1'b0, 1'b1},  // R3 hit
        '{1'b0, 1'b0, A | 22'h1,  16'h0,    1'b0, 1'b1},  // R9 odd byte
        '{1'b1, 1'b0, A,          16'h1111, 1'b1, 1'b1},  // R4 write hit
        '{1'b0, 1'b0, A,          16'h0,    1'b0, 1'b1},  // R4 line updated
        '{1'b0, 1'b0, B,          16'h0,    1'b1, 1'b0},  // R9 conflict
        '{1'b0, 1'b0, A,          16'h0,    1'b1, 1'b0},  // R9 evicted
        '{1'b1, 1'b0, C,          16'h2222, 1'b1, 1'b0},  // R4 write miss
        '{1'b0, 1'b0, C,          16'h0,    1'b1, 1'b0},  // R4 not allocated
        '{1'b0, 1'b0, C,          16'h0,    1'b0, 1'b1},  // R3
        '{1'b0, 1'b0, IO,         16'h0,    1'b1, 1'b1},  // R5 I/O page
        '{1'b0, 1'b0, IO,         16'h0,    1'b1, 1'b1},  // R5 never allocated
        '{1'b0, 1'b1, A,          16'h0,    1'b1, 1'b1},  // R6 no-cache hit drops line
        '{1'b0, 1'b0, A,          16'h0,    1'b1, 1'b0},  // R6 line was dropped
        '{1'b1, 1'b1, A,          16'h3333, 1'b1, 1'b0},  // R6 no-cache write hit
        '{1'b0, 1'b0, A,          16'h0,    1'b1, 1'b0},  // R6 dropped again
        '{1'b0, 1'b0, A,          16'h0,    1'b0, 1'b1},  // R3
        '{1'b0, 1'b0, 22'h3FDFFE, 16'h0,    1'b1, 1'b0},  // R5 just below I/O page
        '{1'b0, 1'b0, 22'h3FDFFE, 16'h0,    1'b0, 1'b1},  // R5 cacheable
        '{1'b0, 1'b0, 22'h3FFFFE, 16'h0,    1'b1, 1'b1}   // R5 same index, I/O page
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] rd, exp;
        int nmem, lat;
        logic hit;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in and right after reset
        chk("R1 hit_o in reset", 32'(hit_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mem_req_o after reset", 32'(mem_req_o), 32'd0);
        chk("R1 cpu_ack_o after reset", 32'(cpu_ack_o), 32'd0);
        chk("R1 hit_o after reset", 32'(hit_o), 32'd0);

        for (int i = 0; i < NV; i++) begin
            exp = model_rd(VECS[i].addr);
            access(VECS[i].we, VECS[i].nc, VECS[i].addr, VECS[i].wd, rd, nmem, lat, hit);
            if (!VECS[i].we) chk($sformatf("vec%0d rdata (R2,R3,R4)", i), 32'(rd), 32'(exp));
            chk($sformatf("vec%0d memory accesses (R4,R5,R6,R9)", i), 32'(nmem), 32'(VECS[i].exp_mem));
            chk($sformatf("vec%0d hit_o (R2,R3,R5)", i), 32'(hit), 32'(VECS[i].exp_hit));
            if (!VECS[i].exp_mem) chk($sformatf("vec%0d R3 hit latency", i), 32'(lat), 32'd1);
        end

        // R7: cache off, everything goes to memory, hit_o unchanged
        ctl_write(1'b0);
        access(1'b0, 1'b0, A, 16'h0, rd, nmem, lat, hit);
        chk("R7 read while off uses memory", 32'(nmem), 32'd1);
        chk("R7 hit_o unchanged", 32'(hit), 32'd1);
        chk("R7 read data", 32'(rd), 32'h3333);
        access(1'b0, 1'b0, A, 16'h0, rd, nmem, lat, hit);
        chk("R7 no allocation while off", 32'(nmem), 32'd1);
        access(1'b1, 1'b0, A, 16'h4444, rd, nmem, lat, hit);
        chk("R7 write while off", 32'(nmem), 32'd1);

        // R8: turning on empties the store, so the stale 3333 is not returned
        ctl_write(1'b1);
        access(1'b0, 1'b0, A, 16'h0, rd, nmem, lat, hit);
        chk("R8 re-enable invalidates", 32'(nmem), 32'd1);
        chk("R8 fresh data", 32'(rd), 32'h4444);
        chk("R8 hit_o miss", 32'(hit), 32'd0);
        ctl_write(1'b1);
        access(1'b0, 1'b0, A, 16'h0, rd, nmem, lat, hit);
        chk("R8 enable while on keeps lines", 32'(nmem), 32'd0);
        chk("R8 hit_o", 32'(hit), 32'd1);

        // R6: another master changes memory; no-cache read sees it and drops the line
        mem_aa[int'(A[21:1])] = 16'h5555;
        access(1'b0, 1'b0, A, 16'h0, rd, nmem, lat, hit);
        chk("R2 cached copy returned", 32'(rd), 32'h4444);
        access(1'b0, 1'b1, A, 16'h0, rd, nmem, lat, hit);
        chk("R6 no-cache read data", 32'(rd), 32'h5555);
        chk("R6 no-cache read uses memory", 32'(nmem), 32'd1);
        access(1'b0, 1'b0, A, 16'h0, rd, nmem, lat, hit);
        chk("R6 refetch after drop", 32'(rd), 32'h5555);
        chk("R6 refetch is a miss", 32'(hit), 32'd0);

        finish_run();
    end
endmodule